// File: doc/BRIEF.md
# Prescaled PWM Bank

This block holds several independent pulse-width-modulation channels behind one small register port. Each channel has one 32-bit control word. That word sets a clock prescaler, an 8-bit high time, a force-high bit and an enable bit. The prescaler divides the system clock by its field value plus one. Each prescaled tick moves an 8-bit phase counter one step, so one output period always lasts 256 ticks. The output is active-high and is asserted while the phase is below the duty value.

Software writes a control word and the channel follows it from the next clock edge. Neither reprogramming nor disabling waits for the running period to end. Clearing the enable bit drops the output at once and returns the counters to zero, so the next enable starts a fresh period.

Top module: `prescaled_pwm_bank`

## Requirements
- R1: After reset every control word reads as zero and every PWM output is low.
- R2: The control word of channel n sits at byte address n*16. A write there stores all 32 bits, and a read at that address returns the last value written, in the same cycle.
- R3: A write to any address whose low four bits are non-zero, or whose channel number is NUM_CH or above, changes no control word and no output. A read of such an address returns zero.
- R4: Control word fields: bits [12:0] are the divider value S, bits [23:16] are the duty D, bit 24 forces full duty, and bit 31 enables the channel. All other bits are stored but have no effect on the output.
- R5: While a channel is enabled, its phase advances once every S+1 clocks and wraps after 255. One period is therefore 256*(S+1) clocks, and S=0 gives the fastest rate, clock/256.
- R6: An enabled channel without force-full drives its output high exactly while the phase is below D. A duty of 0 keeps the output low for the whole period.
- R7: An enabled channel with force-full set holds its output high for the whole period, whatever the value of D.
- R8: A write that clears the enable bit drives the output low from the clock edge that captures the write, even in the middle of a high time. It also resets the prescaler and the phase, so the next enable starts at phase 0.
- R9: A write to an enabled channel that keeps the enable bit set changes the output from the capturing edge onward, and the phase and prescaler continue without a restart.
- R10: A channel's output depends only on its own control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One active-high PWM output per channel |

## Verification
The bench compares each channel's output cycle by cycle over a whole period, for several dividers and duties. It covers duty 0 and 255, force-full with a non-zero duty, and reserved bits set. A prescaler that divides by S instead of S+1, or a compare that uses less-or-equal, fails these runs at their first edge. Disabling in the middle of a high time must pull the output low on the next cycle, and the following enable must start at phase 0; a design that finishes the period first, or keeps its counters, fails here. A duty rewrite in mid-period must neither restart the phase nor wait for the wrap, and writes to misaligned or absent channels must leave every word and output unchanged.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

    localparam int SCALE_W = 13;
    localparam int DUTY_W  = 8;
    localparam int WORD_W  = 32;

    // Layout of one channel control word (MSB first)
    typedef struct packed {
        logic               en;        // [31]
        logic [5:0]         rsv_hi;    // [30:25]
        logic               full;      // [24]
        logic [DUTY_W-1:0]  duty;      // [23:16]
        logic [2:0]         rsv_lo;    // [15:13]
        logic [SCALE_W-1:0] scale;     // [12:0]
    } pwm_ctrl_t;

    typedef struct packed {
        logic [SCALE_W-1:0] presc;
        logic [DUTY_W-1:0]  phase;
    } pwm_cnt_t;

endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output pwm_ctrl_t [NUM_CH-1:0]   ctrl_o
);

    localparam int CH_W = ADDR_W - 4;

    pwm_ctrl_t [NUM_CH-1:0] regs_d, regs_q;
    logic [CH_W-1:0]        sel_ch;
    logic                   hit;

    assign sel_ch = addr[ADDR_W-1:4];
    assign hit    = (addr[3:0] == 4'd0) && (int'(sel_ch) < NUM_CH);

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && (sel_ch == CH_W'(i))) begin
                rdata = regs_q[i];
                if (wr_en) begin
                    regs_d[i] = pwm_ctrl_t'(wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_o = regs_q;

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == '0)); // R3

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit && (sel_ch == CH_W'(g))) |=> (regs_q[g] == $past(wdata))); // R2
        AST_MISS_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            !hit |=> $stable(regs_q[g])); // R3
    end

endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_ctrl_t ctrl_i,
    output logic      pwm_o
);

    pwm_cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!ctrl_i.en) begin
            cnt_d = '0;
        end else if (cnt_q.presc >= ctrl_i.scale) begin
            cnt_d.presc = '0;
            cnt_d.phase = cnt_q.phase + 1'b1;
        end else begin
            cnt_d.presc = cnt_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pwm_o = ctrl_i.en & (ctrl_i.full | (cnt_q.phase < ctrl_i.duty));

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.en |=> (cnt_q.phase == '0 && cnt_q.presc == '0)); // R8

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && $past(ctrl_i.en)) |->
            ((cnt_q.phase == $past(cnt_q.phase)) ||
             (cnt_q.phase == DUTY_W'($past(cnt_q.phase) + 1'b1)))); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && !ctrl_i.full && ctrl_i.duty == '0) |-> !pwm_o); // R6

    AST_FULL_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && ctrl_i.full && $past(ctrl_i.en && ctrl_i.full)) |-> (pwm_o && $past(pwm_o))); // R7

endmodule

// File: rtl/prescaled_pwm_bank.sv
`timescale 1ns/1ps
module prescaled_pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_ctrl_t [NUM_CH-1:0] ctrl;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_o (ctrl)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ctrl[g]),
            .pwm_o  (pwm_out[g])
        );

        AST_OFF_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[g].en |-> !pwm_out[g]); // R8
    end

endmodule

// File: tb/prescaled_pwm_bank_test.sv
`timescale 1ns/1ps
module prescaled_pwm_bank_test;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prescaled_pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {channel, control word}
    localparam logic [33:0] VEC [9] = '{
        {2'd0, 32'h8080_0000},   // R5 R6: S=0, D=128
        {2'd1, 32'h8001_0001},   // R5 R6: S=1, D=1
        {2'd2, 32'h8000_0002},   // R6: D=0 stays low
        {2'd3, 32'h80FF_0000},   // R6: D=255
        {2'd0, 32'h8100_0003},   // R7: full, D=0, S=3
        {2'd1, 32'h8125_0001},   // R7: full, D=37
        {2'd2, 32'h0040_0000},   // R8: not enabled
        {2'd3, 32'h8010_0003},   // R5: S=3, D=16
        {2'd0, 32'h8E40_E000}    // R4: reserved bits set
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic exp_bit(input int j, input logic [31:0] c);
        int s;
        s = int'(c[12:0]);
        if (!c[31]) return 1'b0;
        if (c[24])  return 1'b1;
        return ((j / (s + 1)) % 256) < int'(c[23:16]);
    endfunction

    // Compare pwm_out at each negedge for steps j0 .. j0+n-1
    task automatic run(input string req, input int ch, input logic [31:0] c,
                       input int j0, input int n);
        int bad = 0;
        int fj = 0;
        logic [NUM_CH-1:0] fa = '0;
        logic [NUM_CH-1:0] fe = '0;
        for (int j = j0; j < j0 + n; j++) begin
            logic [NUM_CH-1:0] e;
            e = '0;
            e[ch] = exp_bit(j, c);
            if (pwm_out !== e) begin
                if (bad == 0) begin
                    fa = pwm_out;
                    fe = e;
                    fj = j;
                end
                bad++;
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s ch%0d step %0d actual %b expected %b (%0d bad steps)",
                     req, ch, fj, fa, fe, bad);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        check("R1 outputs low in reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs low after reset", 32'(pwm_out), 32'h0);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ADDR_W'(c * 16), r);
            check("R1 word zero after reset", r, 32'h0);
        end

        // Table walk: each vector runs one full period from a fresh start
        for (int v = 0; v < 9; v++) begin
            int ch;
            logic [31:0] cw;
            ch = int'(VEC[v][33:32]);
            cw = VEC[v][31:0];
            wr(ADDR_W'(ch * 16), 32'h0);
            wr(ADDR_W'(ch * 16), cw);
            rd(ADDR_W'(ch * 16), r);
            check("R2 readback", r, cw);
            run("R4 R5 R6 R7 period", ch, cw, 0, 256 * (int'(cw[12:0]) + 1));
            wr(ADDR_W'(ch * 16), 32'h0);
        end

        // R3: misaligned and absent channels
        wr(8'h10, 32'h8100_0000);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h10, r);
        check("R3 ch1 word unchanged", r, 32'h8100_0000);
        rd(8'h20, r);
        check("R3 ch2 word unchanged", r, 32'h0);
        rd(8'h14, r);
        check("R3 misaligned read zero", r, 32'h0);
        rd(8'h40, r);
        check("R3 absent channel read zero", r, 32'h0);
        check("R3 outputs unchanged", 32'(pwm_out), 32'h2);
        wr(8'h10, 32'h0);

        // R10: two channels together, then one stopped
        wr(8'h00, 32'h8100_0000);
        wr(8'h20, 32'h8100_0000);
        check("R10 both channels high", 32'(pwm_out), 32'h5);
        wr(8'h00, 32'h0);
        check("R10 other channel kept", 32'(pwm_out), 32'h4);
        wr(8'h20, 32'h0);

        // R8: disable mid high time, then fresh restart
        wr(8'h20, 32'h80C8_0000);
        run("R8 before disable", 2, 32'h80C8_0000, 0, 50);
        wr(8'h20, 32'h00C8_0000);
        check("R8 low right after disable", 32'(pwm_out), 32'h0);
        wr(8'h20, 32'h80C8_0000);
        run("R8 restart at phase 0", 2, 32'h80C8_0000, 0, 256);
        wr(8'h20, 32'h0);

        // R9: duty rewrite mid period, no restart
        wr(8'h30, 32'h80C8_0000);
        run("R9 before rewrite", 3, 32'h80C8_0000, 0, 11);
        wr(8'h30, 32'h8005_0000);
        run("R9 after rewrite", 3, 32'h8005_0000, 12, 300);
        wr(8'h30, 32'h0);
        check("R8 final outputs low", 32'(pwm_out), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule